// File: doc/BRIEF.md
# Epoch Backplane Switch Allocator

This block decides, once per epoch, which source card may send to which destination card across a switched backplane. At the epoch strobe it samples a full source-by-destination request matrix, a per-destination inhibit vector (flow control from receivers that cannot take data) and a per-source flag that marks forwarding-engine cards. From these it builds a conflict-free pairing, with at most one destination per source and at most one source per destination. It reports the pairing as a valid bit and a destination index for every source.

The allocation is a greedy scan in two passes. The first pass serves only forwarding-engine sources and the second pass serves line-card sources. Within each pass, sources are visited in a rotated order. Each visited source takes the first free, non-inhibited requested destination, also searched in a rotated order. A free-running LFSR picks both rotation offsets afresh at every epoch, so no port index is favoured over time. Several sources are evaluated per clock by chained combinational lanes, so both passes complete inside the 8 allocation cycles of an epoch.

Requests are levels. A source whose request is not granted keeps it asserted, and it is considered again at the next strobe.

Top module: `bp_alloc`

## Requirements
- R1: After reset, every grant valid bit is 0 and the done pulse is low.
- R2: The edge that samples the strobe counts as edge 1. The done pulse is high for one cycle after edge STEPS+1, which is edge 9 with the defaults. The grant outputs change only at that edge and hold their values until the next result.
- R3: Request bit s*N+d asks for source s to send to destination d. Grant field s sits at grant_dst_o[s*IDX_W +: IDX_W] and is meaningful only when grant_vld_o[s] is 1. Every granted pair was requested in the sampled matrix.
- R4: No destination index appears in more than one valid grant field.
- R5: A destination whose inhibit bit was 1 at the strobe receives no grant in that epoch.
- R6: The pairing is maximal. A requested pair whose destination is not inhibited is left ungranted only if its source or its destination is already granted.
- R7: Forwarding-engine sources take precedence. Consider a forwarding-engine source left ungranted. Each of its requested, non-inhibited destinations is granted to some other forwarding-engine source.
- R8: Under steady contention, where every source requests the same single destination, each source wins at least 5 of 240 epochs.
- R9: A strobe that arrives while an allocation is in progress, other than on its last cycle, is ignored. The running allocation completes on its original schedule with its original inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Allocation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| epoch_i | input | 1 | Epoch strobe, samples the inputs |
| req_i | input | N_PORT*N_PORT | Request matrix, bit s*N_PORT+d |
| inhib_i | input | N_PORT | Per-destination inhibit |
| fe_i | input | N_PORT | Per-source forwarding-engine flag |
| grant_vld_o | output | N_PORT | Per-source grant valid |
| grant_dst_o | output | N_PORT*IDX_W | Per-source granted destination index |
| done_o | output | 1 | One-cycle pulse when new grants are published |

## Verification
A wrong free-destination mask or a lane that skips its source corrupts the pairing directly. It shows up at the very next done pulse as a duplicated destination, a grant to an inhibited card, or a requested pair left idle that should have been taken. A wrong pass order shows up in the same epoch as a line card holding a destination that a waiting forwarding engine asked for. A stuck or biased rotation is invisible in any single epoch. It appears only as a skewed win count across many epochs of single-destination contention, so the bench runs that sweep long enough to expose it.

// File: rtl/bp_alloc_pkg.sv
package bp_alloc_pkg;

  // Adds two indices modulo n. Both inputs are already below n.
  function automatic int unsigned wrap_add(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned n);
    int unsigned s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/bp_alloc_lfsr.sv
module bp_alloc_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state_o
);

  logic [W-1:0] st_q;
  logic [W-1:0] st_d;

  always_comb begin
    st_d = st_q;
    if (step) begin
      if (st_q[0]) st_d = (st_q >> 1) ^ TAPS;
      else         st_d = st_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= SEED;
    else if (step) st_q <= st_d;
  end

  assign state_o = st_q;

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0); // R8

endmodule

// File: rtl/bp_alloc_lane.sv
module bp_alloc_lane #(
  parameter int N = 15,
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] row,
  input  logic [N-1:0] avail,
  input  logic [W-1:0] rot,
  output logic         found,
  output logic [W-1:0] dst,
  output logic [N-1:0] avail_o
);
  import bp_alloc_pkg::*;

  logic [N-1:0] cand;

  always_comb begin
    int unsigned idx;
    cand  = row & avail & {N{en}};
    found = 1'b0;
    dst   = '0;
    // Walk downwards so the lowest rotated position wins.
    for (int q = N - 1; q >= 0; q--) begin
      idx = wrap_add(q, int'(rot), N);
      if (cand[idx]) begin
        found = 1'b1;
        dst   = W'(idx);
      end
    end
  end

  always_comb begin
    avail_o = avail;
    if (found) avail_o[dst] = 1'b0;
  end

  AST_LANE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (avail[dst] && row[dst] && en)); // R3

endmodule

// File: rtl/bp_alloc.sv
module bp_alloc #(
  parameter int               N_PORT    = 15,
  parameter int               LANES     = 4,
  parameter int               LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int              IDX_W     = $clog2(N_PORT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      epoch_i,
  input  logic [N_PORT*N_PORT-1:0]  req_i,
  input  logic [N_PORT-1:0]         inhib_i,
  input  logic [N_PORT-1:0]         fe_i,
  output logic [N_PORT-1:0]         grant_vld_o,
  output logic [N_PORT*IDX_W-1:0]   grant_dst_o,
  output logic                      done_o
);
  import bp_alloc_pkg::*;

  localparam int SLOTS = 2 * N_PORT;
  localparam int STEPS = (SLOTS + LANES - 1) / LANES;
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int HALF  = LFSR_W / 2;

  // Sampled epoch inputs
  logic [N_PORT*N_PORT-1:0] req_q;
  logic [N_PORT-1:0]        inh_q, fe_q;
  logic [IDX_W-1:0]         rs_q, rd_q;
  // Sequencer
  logic                     busy_q, busy_d;
  logic [CNT_W-1:0]         cnt_q, cnt_d;
  // Working pairing
  logic [N_PORT-1:0]        dfree_q, dfree_d;
  logic [N_PORT-1:0]        gv_q, gv_d, gv_w;
  logic [N_PORT*IDX_W-1:0]  gd_q, gd_d, gd_w;
  // Published result
  logic [N_PORT-1:0]        gvo_q, gvo_d;
  logic [N_PORT*IDX_W-1:0]  gdo_q, gdo_d;
  logic                     done_q, done_d;

  logic                     last_w, accept_w;
  logic [LFSR_W-1:0]        lfsr_st;
  logic [IDX_W-1:0]         rs_new, rd_new;

  assign last_w   = busy_q && (cnt_q == CNT_W'(STEPS - 1));
  assign accept_w = epoch_i && (!busy_q || last_w);

  bp_alloc_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (accept_w),
    .state_o (lfsr_st)
  );

  assign rs_new = IDX_W'(int'(lfsr_st[HALF-1:0]) % N_PORT);
  assign rd_new = IDX_W'(int'(lfsr_st[LFSR_W-1:HALF]) % N_PORT);

  // Slot-to-source mapping for each lane in the current step
  logic [LANES-1:0]             lane_en;
  logic [IDX_W-1:0]             lane_src [LANES];
  logic [N_PORT-1:0]            lane_av  [LANES+1];
  logic [LANES-1:0]             lane_hit;
  logic [IDX_W-1:0]             lane_dst [LANES];

  always_comb begin
    int slot, pos;
    bit pass_lc;
    for (int l = 0; l < LANES; l++) begin
      slot        = int'(cnt_q) * LANES + l;
      pass_lc     = (slot >= N_PORT);
      pos         = pass_lc ? slot - N_PORT : slot;
      lane_src[l] = '0;
      lane_en[l]  = 1'b0;
      if (busy_q && slot < SLOTS) begin
        lane_src[l] = IDX_W'(wrap_add(pos, int'(rs_q), N_PORT));
        lane_en[l]  = (fe_q[lane_src[l]] != pass_lc);
      end
    end
  end

  assign lane_av[0] = dfree_q & ~inh_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    bp_alloc_lane #(.N(N_PORT), .W(IDX_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (lane_en[l]),
      .row     (req_q[int'(lane_src[l])*N_PORT +: N_PORT]),
      .avail   (lane_av[l]),
      .rot     (rd_q),
      .found   (lane_hit[l]),
      .dst     (lane_dst[l]),
      .avail_o (lane_av[l+1])
    );
  end

  // Working pairing after this step's lanes
  always_comb begin
    gv_w    = gv_q;
    gd_w    = gd_q;
    dfree_d = dfree_q;
    for (int l = 0; l < LANES; l++) begin
      if (lane_hit[l]) begin
        gv_w[lane_src[l]]                          = 1'b1;
        gd_w[int'(lane_src[l])*IDX_W +: IDX_W]     = lane_dst[l];
        dfree_d[lane_dst[l]]                       = 1'b0;
      end
    end
  end

  // Next-state of the sequencer and the outputs
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    gv_d   = gv_q;
    gd_d   = gd_q;
    gvo_d  = gvo_q;
    gdo_d  = gdo_q;
    done_d = 1'b0;
    if (busy_q) begin
      gv_d  = gv_w;
      gd_d  = gd_w;
      cnt_d = cnt_q + 1'b1;
      if (last_w) begin
        busy_d = 1'b0;
        cnt_d  = '0;
        gvo_d  = gv_w;
        gdo_d  = gd_w;
        done_d = 1'b1;
      end
    end
    if (accept_w) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      gv_d   = '0;
      gd_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      gvo_q  <= '0;
      gdo_q  <= '0;
      gv_q   <= '0;
      gd_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      gvo_q  <= gvo_d;
      gdo_q  <= gdo_d;
      gv_q   <= gv_d;
      gd_q   <= gd_d;
    end
  end

  // Destination-free mask: reloaded at accept, updated while running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dfree_q <= '0;
    else if (accept_w) dfree_q <= '1;
    else if (busy_q)   dfree_q <= dfree_d;
  end

  // Input sample registers, enabled by accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      inh_q <= '0;
      fe_q  <= '0;
      rs_q  <= '0;
      rd_q  <= '0;
    end else if (accept_w) begin
      req_q <= req_i;
      inh_q <= inhib_i;
      fe_q  <= fe_i;
      rs_q  <= rs_new;
      rd_q  <= rd_new;
    end
  end

  assign grant_vld_o = gvo_q;
  assign grant_dst_o = gdo_q;
  assign done_o      = done_q;

  // Checks on the pairing about to be published
  for (genvar d = 0; d < N_PORT; d++) begin : g_dchk
    logic [N_PORT-1:0] hit;
    always_comb begin
      for (int s = 0; s < N_PORT; s++)
        hit[s] = gv_w[s] && (gd_w[s*IDX_W +: IDX_W] == IDX_W'(d));
    end
    AST_ONE_PER_DST: assert property (@(posedge clk) disable iff (!rst_n)
      last_w |-> ($countones(hit) <= 1)); // R4
    AST_INHIB_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (last_w && inh_q[d]) |-> (hit == '0)); // R5
  end

  for (genvar s = 0; s < N_PORT; s++) begin : g_schk
    AST_PAIR_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
      (last_w && gv_w[s]) |-> req_q[s*N_PORT + int'(gd_w[s*IDX_W +: IDX_W])]); // R3
  end

  if (STEPS > 1) begin : g_pulse
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R2
  end

  AST_MID_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_w && epoch_i) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1)); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_d |=> $stable(grant_vld_o)); // R2

endmodule

// File: tb/sim_bp_alloc.sv
module sim_bp_alloc;
  localparam int N = 15;
  localparam int W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             epoch;
  logic [N*N-1:0]   req;
  logic [N-1:0]     inh, fe;
  logic [N-1:0]     gvld;
  logic [N*W-1:0]   gdst;
  logic             done;

  int total = 0;
  int bad   = 0;
  int wins [N];

  always #5 clk = ~clk;

  bp_alloc u0 (
    .clk(clk), .rst_n(rst_n), .epoch_i(epoch), .req_i(req),
    .inhib_i(inh), .fe_i(fe), .grant_vld_o(gvld), .grant_dst_o(gdst),
    .done_o(done)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int gdst_of(input int s);
    return int'(gdst[s*W +: W]);
  endfunction

  // Checks the published pairing against the sampled inputs.
  task automatic judge();
    int owner [N];
    int dup = 0, unreq = 0, inhg = 0, idle = 0, prio = 0;
    for (int d = 0; d < N; d++) owner[d] = -1;
    for (int s = 0; s < N; s++) if (gvld[s]) begin
      int d = gdst_of(s);
      if (d >= N) unreq++;
      else begin
        if (owner[d] != -1) dup++;
        owner[d] = s;
        if (!req[s*N+d]) unreq++;
        if (inh[d]) inhg++;
      end
    end
    for (int s = 0; s < N; s++) if (!gvld[s]) begin
      for (int d = 0; d < N; d++) if (req[s*N+d] && !inh[d]) begin
        if (owner[d] == -1) idle++;
        else if (fe[s] && !fe[owner[d]]) prio++;
      end
    end
    chk(unreq == 0, "R3 unrequested grants", unreq, 0);
    chk(dup == 0,   "R4 shared destinations", dup, 0);
    chk(inhg == 0,  "R5 grants to inhibited", inhg, 0);
    chk(idle == 0,  "R6 idle grantable pairs", idle, 0);
    chk(prio == 0,  "R7 line card over engine", prio, 0);
    for (int s = 0; s < N; s++) if (gvld[s]) wins[s]++;
  endtask

  // One epoch: strobe, optional mid-run strobe, latency and hold checks.
  task automatic run_epoch(input int mid_at);
    int cyc = 0;
    logic [N-1:0] held;
    logic [N*N-1:0] keep;
    keep = req;
    @(negedge clk);
    epoch = 1'b1;
    while (cyc < 40) begin
      @(negedge clk);
      cyc++;
      epoch = (mid_at != 0 && cyc == mid_at);
      if (epoch) req = '0;
      if (done) break;
    end
    epoch = 1'b0;
    req   = keep;
    chk(cyc == 9, "R2 result latency", cyc, 9);
    judge();
    held = gvld;
    @(negedge clk);
    chk(gvld == held && !done, "R2 result held", int'(gvld), int'(held));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0; epoch = 1'b0; req = '0; inh = '0; fe = '0;
    for (int s = 0; s < N; s++) wins[s] = 0;
    repeat (3) @(negedge clk);
    chk(gvld == '0 && !done, "R1 reset outputs", int'(gvld), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Full matrix: a perfect pairing is expected
    req = '1;
    run_epoch(0);
    chk($countones(gvld) == N, "R6 full matrix grants", $countones(gvld), N);

    // Everything inhibited
    inh = '1;
    run_epoch(0);
    chk(gvld == '0, "R5 all inhibited", $countones(gvld), 0);
    inh = '0;

    // Identity requests
    req = '0;
    for (int s = 0; s < N; s++) req[s*N+s] = 1'b1;
    run_epoch(0);
    cnt = 0;
    for (int s = 0; s < N; s++) if (gvld[s] && gdst_of(s) == s) cnt++;
    chk(cnt == N, "R3 identity pairing", cnt, N);

    // Single engine among contenders for one destination
    req = '0;
    for (int s = 0; s < N; s++) req[s*N+3] = 1'b1;
    fe = '0; fe[11] = 1'b1;
    for (int e = 0; e < 20; e++) begin
      run_epoch(0);
      chk(gvld == (N'(1) << 11) && gdst_of(11) == 3, "R7 engine wins",
          int'(gvld), 1 << 11);
    end
    fe = '0;

    // Random sweep over density, inhibits and engine flags
    for (int e = 0; e < 150; e++) begin
      int dens = 5 + (e % 6) * 15;
      for (int b = 0; b < N*N; b++) req[b] = ($urandom_range(99) < dens);
      for (int d = 0; d < N; d++) inh[d] = ($urandom_range(99) < 20);
      for (int s = 0; s < N; s++) fe[s]  = ($urandom_range(99) < 30);
      run_epoch(0);
    end
    inh = '0; fe = '0;

    // Fairness under single-destination contention
    for (int s = 0; s < N; s++) wins[s] = 0;
    req = '0;
    for (int s = 0; s < N; s++) req[s*N] = 1'b1;
    for (int e = 0; e < 240; e++) run_epoch(0);
    for (int s = 0; s < N; s++)
      chk(wins[s] >= 5, "R8 long-run share", wins[s], 5);

    // Strobe in the middle of a run, with the request matrix cleared
    req = '0;
    for (int s = 0; s < N; s++) req[s*N + ((s + 1) % N)] = 1'b1;
    run_epoch(4);
    chk($countones(gvld) == N, "R9 mid strobe ignored", $countones(gvld), N);
    cnt = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (done) cnt++;
    end
    chk(cnt == 0, "R9 no extra result", cnt, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule